// File: doc/BRIEF.md
# Scaled 8-Point Forward DCT Butterfly

This block is a fully pipelined forward transform for one row or one column of an 8x8 image block. Each clock it can take a vector of eight signed samples. A fixed number of cycles later it returns eight signed coefficients in natural index order. The transform uses a fast factorisation that needs only five constant multiplies. Every value is a fixed-point integer of the lane width.

Each coefficient leaves the block multiplied by its own fixed scale factor. A downstream quantiser is expected to fold those factors into its divisor table. This keeps normalisation, rounding and saturation out of the datapath.

A two-dimensional transform uses two instances, or one instance used twice, with a transpose store between the passes.

Each constant product works in four steps:
- The operand is shifted left by two bits.
- It is multiplied, as a signed lane-width value, by an 8-fractional-bit constant that has been shifted left by six bits.
- The 32-bit product is formed.
- Only its upper half is kept.

Top module: `dct8_scaled_fdct`

## Requirements
- R1: The first stage forms `s(i) = x(i) + x(7-i)` and `d(7-i) = x(i) - x(7-i)` for i = 0..3. Lane i of `in_samples` is bits [16i+15:16i].
- R2: `y0 = (s0+s3) + (s1+s2)` and `y4 = (s0+s3) - (s1+s2)`. Lane k of `out_coefs` holds yk at bits [16k+15:16k].
- R3: `y2 = e13 + z1` and `y6 = e13 - z1`. Here `e13 = s0-s3` and `z1 = M((s1-s2)+e13, 181)`.
- R4: The odd terms use `o10 = d4+d5`, `o11 = d5+d6` and `o12 = d6+d7`. Each of o10 and o12 is shifted left by 2 before any further use. From there:
  - `z5` is the product with 98 of the shifted o10 minus the shifted o12.
  - `z2` is the product of the shifted o10 with 139, plus z5.
  - `z4` is the product of the shifted o12 with 334, plus z5.
  - `z3 = M(o11, 181)`.
- R5: With `z11 = d7+z3` and `z13 = d7-z3`, the odd outputs are `y1 = z11+z4`, `y7 = z11-z4`, `y5 = z13+z2` and `y3 = z13-z2`.
- R6: `M(v, k)` shifts v left by 2 with 16-bit wrap and multiplies it as signed by `k*64`. It returns bits [31:16] of the product, which is a floor with no rounding term. For example, an impulse of 1 on lane 0 gives y3 = 2 and y5 = 0.
- R7: Every sum, difference and shift wraps in 16-bit two's complement. Full-scale inputs produce wrapped results, never clipped ones.
- R8: `out_valid` rises exactly 4 clocks after the edge at which `in_valid` was sampled high. Back-to-back vectors come out on consecutive cycles in input order.
- R9: A cycle with synchronous reset high clears the pipeline. `out_valid` is low on the following cycle whatever `in_valid` was during the reset.
- R10: An input vector whose eight lanes are equal produces zero in all of y1..y7.
- R11: A cycle with `in_valid` low produces no output: `out_valid` is low 4 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector valid |
| in_samples | input | 128 | Eight signed 16-bit samples, lane i at [16i+15:16i] |
| out_valid | output | 1 | Output vector valid, registered |
| out_coefs | output | 128 | Eight signed 16-bit scaled coefficients, lane k at [16k+15:16k] |

## Verification
On every valid cycle the assertions check the following:
- The valid flag moves through exactly four stages.
- Reset empties the pipe.
- A flat input vector leaves only the DC lane non-zero.
- The pair sums of the output butterflies match the stage terms that feed them: y0+y4, y2+y6, y1+y7 and y3+y5.

Only the bench scenarios can show the rest:
- the individual constant products;
- the floor behaviour of the upper-half multiply on negative operands;
- wraparound at full scale;
- the bit-exact agreement of every coefficient with an independent integer model.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
  localparam int FRAC_BITS = 8;   // fractional bits of the constants
  localparam int PRE_SHIFT = 2;   // operand headroom shift before multiply
  localparam int K_0382 = 98;
  localparam int K_0541 = 139;
  localparam int K_0707 = 181;
  localparam int K_1306 = 334;
  localparam int LANES  = 8;
  localparam int LAT    = 4;      // pipeline depth in clocks
endpackage

// File: rtl/dct8_cmul.sv
module dct8_cmul #(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int PRE  = 2,
  parameter int K    = 181
) (
  input  logic signed [W-1:0] a_pre,   // operand, already pre-shifted
  output logic signed [W-1:0] p_hi
);
  localparam int KS = K << (W - PRE - FRAC);
  localparam logic signed [W-1:0] KC = W'(KS);

  logic signed [2*W-1:0] prod;

  assign prod = a_pre * KC;
  assign p_hi = prod[2*W-1:W];     // upper half: floor, no rounding
endmodule

// File: rtl/dct8_even.sv
module dct8_even #(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int PRE  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                c_valid,
  input  logic signed [W-1:0] s0,
  input  logic signed [W-1:0] s1,
  input  logic signed [W-1:0] s2,
  input  logic signed [W-1:0] s3,
  output logic signed [W-1:0] y0,
  output logic signed [W-1:0] y2,
  output logic signed [W-1:0] y4,
  output logic signed [W-1:0] y6
);
  logic signed [W-1:0] b_e10, b_e11, b_e13, b_q;
  logic signed [W-1:0] c_e10, c_e11, c_e13, c_z1;
  logic signed [W-1:0] z1_w;

  // stage B: second butterfly, pre-shifted rotation operand
  always_ff @(posedge clk) begin
    b_e10 <= s0 + s3;
    b_e11 <= s1 + s2;
    b_e13 <= s0 - s3;
    b_q   <= W'(((s1 - s2) + (s0 - s3)) <<< PRE);
  end

  dct8_cmul #(.W(W), .FRAC(FRAC), .PRE(PRE), .K(dct8_pkg::K_0707)) u_m0707 (
    .a_pre (b_q),
    .p_hi  (z1_w)
  );

  // stage C: product registered
  always_ff @(posedge clk) begin
    c_e10 <= b_e10;
    c_e11 <= b_e11;
    c_e13 <= b_e13;
    c_z1  <= z1_w;
  end

  // stage D: output butterfly
  always_ff @(posedge clk) begin
    y0 <= c_e10 + c_e11;
    y4 <= c_e10 - c_e11;
    y2 <= c_e13 + c_z1;
    y6 <= c_e13 - c_z1;
  end

  // R2
  dc_pair_chk: assert property (@(posedge clk) disable iff (rst)
    c_valid |=> (W'(y0 + y4) == W'($past(c_e10) <<< 1)));
  // R3
  mid_pair_chk: assert property (@(posedge clk) disable iff (rst)
    c_valid |=> (W'(y2 + y6) == W'($past(c_e13) <<< 1)));
endmodule

// File: rtl/dct8_odd.sv
module dct8_odd #(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int PRE  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                c_valid,
  input  logic signed [W-1:0] d4,
  input  logic signed [W-1:0] d5,
  input  logic signed [W-1:0] d6,
  input  logic signed [W-1:0] d7,
  output logic signed [W-1:0] y1,
  output logic signed [W-1:0] y3,
  output logic signed [W-1:0] y5,
  output logic signed [W-1:0] y7
);
  logic signed [W-1:0] b_a10, b_a11, b_a12, b_d7;
  logic signed [W-1:0] c_z2, c_z3, c_z4, c_d7;
  logic signed [W-1:0] diff_w, z5_w, p541_w, p1306_w, z3_w;
  logic signed [W-1:0] z11_w, z13_w;

  // stage B: odd sums, shifted before any product or difference
  always_ff @(posedge clk) begin
    b_a10 <= W'((d4 + d5) <<< PRE);
    b_a11 <= W'((d5 + d6) <<< PRE);
    b_a12 <= W'((d6 + d7) <<< PRE);
    b_d7  <= d7;
  end

  assign diff_w = b_a10 - b_a12;

  dct8_cmul #(.W(W), .FRAC(FRAC), .PRE(PRE), .K(dct8_pkg::K_0382)) u_m0382 (
    .a_pre (diff_w), .p_hi (z5_w));
  dct8_cmul #(.W(W), .FRAC(FRAC), .PRE(PRE), .K(dct8_pkg::K_0541)) u_m0541 (
    .a_pre (b_a10), .p_hi (p541_w));
  dct8_cmul #(.W(W), .FRAC(FRAC), .PRE(PRE), .K(dct8_pkg::K_1306)) u_m1306 (
    .a_pre (b_a12), .p_hi (p1306_w));
  dct8_cmul #(.W(W), .FRAC(FRAC), .PRE(PRE), .K(dct8_pkg::K_0707)) u_m0707 (
    .a_pre (b_a11), .p_hi (z3_w));

  // stage C: rotation results
  always_ff @(posedge clk) begin
    c_z2 <= p541_w + z5_w;
    c_z4 <= p1306_w + z5_w;
    c_z3 <= z3_w;
    c_d7 <= b_d7;
  end

  assign z11_w = c_d7 + c_z3;
  assign z13_w = c_d7 - c_z3;

  // stage D: output butterfly
  always_ff @(posedge clk) begin
    y1 <= z11_w + c_z4;
    y7 <= z11_w - c_z4;
    y5 <= z13_w + c_z2;
    y3 <= z13_w - c_z2;
  end

  // R5
  odd_outer_chk: assert property (@(posedge clk) disable iff (rst)
    c_valid |=> (W'(y1 + y7) == W'(($past(c_d7) + $past(c_z3)) <<< 1)));
  // R5
  odd_inner_chk: assert property (@(posedge clk) disable iff (rst)
    c_valid |=> (W'(y3 + y5) == W'(($past(c_d7) - $past(c_z3)) <<< 1)));
endmodule

// File: rtl/dct8_scaled_fdct.sv
module dct8_scaled_fdct #(
  parameter int W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic [dct8_pkg::LANES*W-1:0]   in_samples,
  output logic                           out_valid,
  output logic [dct8_pkg::LANES*W-1:0]   out_coefs
);
  import dct8_pkg::*;

  localparam int HALF = LANES / 2;

  logic signed [W-1:0] x   [LANES];
  logic signed [W-1:0] a_s [HALF];
  logic signed [W-1:0] a_d [HALF];   // a_d[j] holds d(4+j)
  logic [LANES-1:0]    lane_eq;
  logic [LAT-1:0]      vpipe;
  logic [LAT-1:0]      flat_pipe;
  logic signed [W-1:0] y [LANES];

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_unpack
      assign x[i] = in_samples[i*W +: W];
      assign lane_eq[i] = (x[i] == x[0]);
      assign out_coefs[i*W +: W] = y[i];
    end
    for (i = 0; i < HALF; i++) begin : g_stage_a
      always_ff @(posedge clk) begin
        a_s[i]        <= x[i] + x[LANES-1-i];
        a_d[HALF-1-i] <= x[i] - x[LANES-1-i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe     <= '0;
      flat_pipe <= '0;
    end else begin
      vpipe     <= {vpipe[LAT-2:0], in_valid};
      flat_pipe <= {flat_pipe[LAT-2:0], in_valid & (&lane_eq)};
    end
  end

  assign out_valid = vpipe[LAT-1];

  dct8_even #(.W(W), .FRAC(FRAC_BITS), .PRE(PRE_SHIFT)) u_even (
    .clk (clk), .rst (rst), .c_valid (vpipe[2]),
    .s0 (a_s[0]), .s1 (a_s[1]), .s2 (a_s[2]), .s3 (a_s[3]),
    .y0 (y[0]), .y2 (y[2]), .y4 (y[4]), .y6 (y[6])
  );

  dct8_odd #(.W(W), .FRAC(FRAC_BITS), .PRE(PRE_SHIFT)) u_odd (
    .clk (clk), .rst (rst), .c_valid (vpipe[2]),
    .d4 (a_d[0]), .d5 (a_d[1]), .d6 (a_d[2]), .d7 (a_d[3]),
    .y1 (y[1]), .y3 (y[3]), .y5 (y[5]), .y7 (y[7])
  );

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##4 out_valid);
  // R11
  bubble_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##4 !out_valid);
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid);
  // R10
  flat_ac_zero_chk: assert property (@(posedge clk) disable iff (rst)
    flat_pipe[LAT-1] |-> (out_valid && out_coefs[LANES*W-1:W] == '0));
endmodule

// File: tb/dct8_scaled_fdct_tb_top.sv
module dct8_scaled_fdct_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [8*W-1:0] in_samples = '0;
  logic out_valid;
  logic [8*W-1:0] out_coefs;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_on = 0;

  int          q_cyc[$];
  logic [127:0] q_val[$];
  string       q_tag[$];

  dct8_scaled_fdct #(.W(W)) dut_i (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_samples (in_samples),
    .out_valid (out_valid), .out_coefs (out_coefs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // floor(a_pre * k*64 / 2^16), a_pre already shifted
  function automatic logic signed [15:0] mh(input logic signed [15:0] a, input int k);
    int p;
    p = int'(a) * (k * 64);
    return p[31:16];
  endfunction

  function automatic logic signed [15:0] sh2(input logic signed [15:0] v);
    logic signed [15:0] r;
    r = v <<< 2;
    return r;
  endfunction

  function automatic logic [127:0] ref_dct(input logic [127:0] xin);
    logic signed [15:0] x[8];
    logic signed [15:0] s0, s1, s2, s3, d4, d5, d6, d7;
    logic signed [15:0] e10, e11, e12, e13, z1, o10, o11, o12, z2, z3, z4, z5, z11, z13;
    logic signed [15:0] y[8];
    logic [127:0] r;
    for (int k = 0; k < 8; k++) x[k] = xin[16*k +: 16];
    s0 = x[0] + x[7]; d7 = x[0] - x[7];
    s1 = x[1] + x[6]; d6 = x[1] - x[6];
    s2 = x[2] + x[5]; d5 = x[2] - x[5];
    s3 = x[3] + x[4]; d4 = x[3] - x[4];
    e10 = s0 + s3; e13 = s0 - s3; e11 = s1 + s2; e12 = s1 - s2;
    y[0] = e10 + e11; y[4] = e10 - e11;
    z1 = mh(sh2(e12 + e13), 181);
    y[2] = e13 + z1; y[6] = e13 - z1;
    o10 = sh2(d4 + d5); o11 = sh2(d5 + d6); o12 = sh2(d6 + d7);
    z5 = mh(o10 - o12, 98);
    z2 = mh(o10, 139) + z5;
    z4 = mh(o12, 334) + z5;
    z3 = mh(o11, 181);
    z11 = d7 + z3; z13 = d7 - z3;
    y[5] = z13 + z2; y[3] = z13 - z2;
    y[1] = z11 + z4; y[7] = z11 - z4;
    for (int k = 0; k < 8; k++) r[16*k +: 16] = y[k];
    return r;
  endfunction

  task automatic drive(input logic [127:0] v, input string tag);
    @(negedge clk);
    in_valid   = 1'b1;
    in_samples = v;
    q_cyc.push_back(cyc + 4);
    q_val.push_back(ref_dct(v));
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_samples = {8{16'hDEAD}};
  endtask

  function automatic logic [127:0] flat(input logic [15:0] v);
    return {8{v}};
  endfunction

  function automatic string lane_req(input int k);
    if (k == 0 || k == 4) return "R2";
    if (k == 2 || k == 6) return "R3";
    return "R5";
  endfunction

  // scoreboard, sampled at the falling edge
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      bit exp_v;
      exp_v = (q_cyc.size() > 0) && (q_cyc[0] == cyc);
      checks++;
      if (out_valid !== exp_v) begin
        errors++;
        $display("FAIL R8/R11 cycle %0d: out_valid=%b expected=%b", cyc, out_valid, exp_v);
      end
      if (exp_v) begin
        for (int k = 0; k < 8; k++) begin
          checks++;
          if (out_coefs[16*k +: 16] !== q_val[0][16*k +: 16]) begin
            errors++;
            $display("FAIL %s [%s] y%0d: got %0d expected %0d", lane_req(k), q_tag[0], k,
                     $signed(out_coefs[16*k +: 16]), $signed(q_val[0][16*k +: 16]));
          end
        end
        void'(q_cyc.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R9: in_valid held high during reset must not leak out
    in_valid = 1'b1;
    in_samples = flat(16'd7);
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 during reset: out_valid=%b expected=0", out_valid);
    end
    rst = 1'b0;
    in_valid = 1'b0;
    mon_on = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R9 after reset: out_valid=%b expected=0", out_valid);
      end
    end

    // R1: unit impulse on each lane, back to back
    for (int k = 0; k < 8; k++) drive(128'd1 << (16*k), "R1 impulse");
    // R6: small negative and positive impulses exercise floor of upper half
    drive({112'd0, 16'hFFFF}, "R6 neg impulse");
    drive({16'd3, 96'd0, 16'hFFFD}, "R6 odd floor");
    idle();
    // R4: odd-only patterns (antisymmetric vectors)
    drive({16'hFFF6, 16'hFFEC, 16'hFFE2, 16'hFFD8, 16'd40, 16'd30, 16'd20, 16'd10}, "R4 ramp");
    drive({16'd0, 16'd0, 16'd0, 16'hFF00, 16'd256, 16'd0, 16'd0, 16'd0}, "R4 centre");
    idle(); idle();
    // R10: flat vectors
    drive(flat(16'd100), "R10 flat");
    drive(flat(16'h8000), "R10 R7 flat min");
    drive(flat(16'h7FFF), "R10 R7 flat max");
    // R7: full-scale alternation and extremes wrap
    drive({4{16'h7FFF, 16'h8000}}, "R7 alternate");
    drive({{4{16'h8000}}, {4{16'h7FFF}}}, "R7 step");
    drive({16'h8000, {6{16'h0000}}, 16'h7FFF}, "R7 edge");
    idle();
    // R8, R11: random stream with bubbles
    for (int n = 0; n < 400; n++) begin
      logic [127:0] v;
      for (int k = 0; k < 4; k++) v[32*k +: 32] = $urandom();
      if (($urandom() % 4) == 0) idle();
      else if (($urandom() % 8) == 0) begin
        for (int k = 0; k < 8; k++) v[16*k +: 16] = (($urandom() % 2) == 1) ? 16'h7FFF : 16'h8000;
        drive(v, "R7 random extreme");
      end else drive(v, "R8 random");
    end
    idle();
    repeat (8) @(negedge clk);
    checks++;
    if (q_cyc.size() != 0) begin
      errors++;
      $display("FAIL R8 drain: got %0d pending expected 0", q_cyc.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule